// File: doc/BRIEF.md
# Radix Page Table Walker

This block turns a virtual address into a final page table entry. It walks a radix tree of page tables, one entry fetched per level through a simple 64-bit read port, from the highest level down to the lowest. The tree is rooted at a base value that is aligned to a page. It stops as soon as it reaches a leaf entry or an invalid entry. Address translation can also be switched off. The block then builds an identity mapping with every permission granted, at once and without touching memory.

A requester raises `req_valid` for one cycle while the walker is idle. It supplies the virtual address, the root base and the translation-enable flag. Memory responds on `mem_rsp_valid` some cycles after each `mem_rd_valid` pulse. The walker raises `done` for one cycle when `result_pte` holds the answer. A memory-size input bounds every entry fetch, so a table that points outside memory yields an invalid result instead of a read. Caching of results and permission checks belong to the blocks around the walker.

Top module: `radix_pt_walker`

## Requirements
- R1: While reset is asserted (active-low, asynchronous), and after its release, `busy`, `done` and `mem_rd_valid` are low and `result_pte` is all zeros. A reset during a walk abandons it.
- R2: A request accepted with `xlate_en` low gives `done` high, with `busy` low, in the cycle after the accepting edge. It issues no memory read. The result has bit 0 = (va < mem_size), bit 1 = 1, bits 3:2 = 0, bits 9:4 all ones, bits 11:10 = 0 and bits 63:12 = va[63:12].
- R3: An entry has its valid flag in bit 0, its leaf flag in bit 1 and its page number in bits 63:12. A walk that ends on a fetched entry returns that entry with bit 0 replaced by the AND of its bits 0 and 1. All other bits are unchanged.
- R4: The first read of a walk goes to the root base with bits 11:0 cleared, plus 8 × va[47:39]. Every read address is a multiple of 8.
- R5: After a valid non-leaf entry at level i > 0, the next read goes to (page number << 12) + 8 × va[12+9(i−1) +: 9]. Levels run from 3 down to 0.
- R6: A fetched entry with bit 0 clear ends the walk. No further reads are made and the result has bit 0 clear.
- R7: A fetched entry with bits 0 and 1 both set ends the walk at any level. The result equals that entry.
- R8: A valid non-leaf entry fetched at level 0 ends the walk after four reads. The result has bit 0 clear.
- R9: When an entry address is at or above `mem_size`, that read is not issued. The walk ends with an all-zero result.
- R10: At most one read is outstanding. `mem_rd_valid` pulses for one cycle per read and stays low until the response arrives. `busy` is high from the cycle after acceptance until `done`.
- R11: A `req_valid` raised while `busy` is high is ignored. This includes the edge on which the final response arrives.
- R12: `done` is a one-cycle pulse seen with `busy` low. `result_pte` keeps its value until the next `done`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Walk request, sampled only while idle |
| req_va | input | 64 | Virtual address to translate |
| req_base | input | 64 | Root table base (low 12 bits ignored) |
| xlate_en | input | 1 | Translation enable; low selects identity mapping |
| mem_size | input | 64 | Bytes of memory; bounds every entry fetch |
| busy | output | 1 | A walk is in progress |
| mem_rd_valid | output | 1 | Read request pulse for one 64-bit entry |
| mem_rd_addr | output | 64 | Byte address of the entry to read |
| mem_rsp_valid | input | 1 | Read data is valid |
| mem_rsp_data | input | 64 | Entry returned by memory |
| done | output | 1 | Result valid pulse |
| result_pte | output | 64 | Resulting entry |

## Verification
Two things can land on the same clock edge: the memory response that finishes a walk, and a new request from the requester. The walker must let the response finish the walk and drop the request. To provoke this, the bench holds `req_valid` high, with a different address, for the whole of a four-level walk, including the terminating edge. It lowers the request only once `done` is seen. The bench then judges three things: the result matches the first address's leaf, the read log shows the first address's path, and no read or `done` follows.

// File: rtl/radix_pt_walker_pkg.sv
package radix_pt_walker_pkg;

   typedef enum logic [1:0] {
      WS_IDLE  = 2'd0,
      WS_ISSUE = 2'd1,
      WS_WAIT  = 2'd2
   } walk_state_e;

   // flag positions inside the low page-offset bits of an entry
   localparam int unsigned FLG_VALID = 0;
   localparam int unsigned FLG_LEAF  = 1;
   localparam int unsigned FLG_REF   = 2;
   localparam int unsigned FLG_DIRTY = 3;
   localparam int unsigned FLG_PERM_LSB = 4;
   localparam int unsigned FLG_PERM_W   = 6;
   localparam int unsigned FLG_BITS     = 12;

endpackage

// File: rtl/radix_pt_walker_index_sel.sv
module radix_pt_walker_index_sel #(
   parameter int unsigned ADDR_W   = 64,
   parameter int unsigned PG_SHIFT = 12,
   parameter int unsigned LEVELS   = 4,
   parameter int unsigned IDX_W    = 9,
   parameter int unsigned OFF_BITS = 3,
   parameter int unsigned LVL_W    = 2
) (
   input  logic [ADDR_W-1:0] va,
   input  logic [ADDR_W-1:0] base,
   input  logic [LVL_W-1:0]  level,
   input  logic [ADDR_W-1:0] mem_size,
   output logic [ADDR_W-1:0] entry_addr,
   output logic              out_of_range
);

   logic [IDX_W-1:0] lvl_idx [LEVELS];

   for (genvar g = 0; g < LEVELS; g++) begin : g_lvl
      localparam int unsigned LSB = PG_SHIFT + g * IDX_W;
      assign lvl_idx[g] = va[LSB +: IDX_W];
   end

   logic [IDX_W-1:0]  sel_idx;
   logic [ADDR_W-1:0] byte_off;

   always_comb begin
      sel_idx = lvl_idx[level];
      byte_off = ADDR_W'(sel_idx) << OFF_BITS;
      entry_addr = base + byte_off;
      out_of_range = (entry_addr >= mem_size);
   end

endmodule

// File: rtl/radix_pt_walker_identity.sv
module radix_pt_walker_identity
   import radix_pt_walker_pkg::*;
#(
   parameter int unsigned ADDR_W   = 64,
   parameter int unsigned PTE_W    = 64,
   parameter int unsigned PG_SHIFT = 12
) (
   input  logic [ADDR_W-1:0] va,
   input  logic [ADDR_W-1:0] mem_size,
   output logic [PTE_W-1:0]  pte
);

   localparam int unsigned PPN_W = PTE_W - PG_SHIFT;
   localparam int unsigned VPN_W = ADDR_W - PG_SHIFT;

   logic [PPN_W-1:0] ppn;

   if (PPN_W >= VPN_W) begin : g_wide_ppn
      assign ppn = PPN_W'(va[ADDR_W-1:PG_SHIFT]);
   end else begin : g_narrow_ppn
      assign ppn = va[PG_SHIFT +: PPN_W];
   end

   always_comb begin
      pte = '0;
      pte[FLG_VALID] = (va < mem_size);
      pte[FLG_LEAF]  = 1'b1;
      pte[FLG_REF]   = 1'b0;
      pte[FLG_DIRTY] = 1'b0;
      pte[FLG_PERM_LSB +: FLG_PERM_W] = '1;
      pte[PTE_W-1:PG_SHIFT] = ppn;
   end

endmodule

// File: rtl/radix_pt_walker_step.sv
module radix_pt_walker_step
   import radix_pt_walker_pkg::*;
#(
   parameter int unsigned ADDR_W   = 64,
   parameter int unsigned PTE_W    = 64,
   parameter int unsigned PG_SHIFT = 12,
   parameter int unsigned LVL_W    = 2
) (
   input  logic [PTE_W-1:0]  entry,
   input  logic [LVL_W-1:0]  level,
   output logic              stop,
   output logic [ADDR_W-1:0] next_base,
   output logic [PTE_W-1:0]  final_pte
);

   logic [PTE_W-1:0] page_base;
   logic             ent_valid;
   logic             ent_leaf;

   always_comb begin
      ent_valid = entry[FLG_VALID];
      ent_leaf  = entry[FLG_LEAF];
      stop      = !ent_valid || ent_leaf || (level == '0);
      page_base = {entry[PTE_W-1:PG_SHIFT], {PG_SHIFT{1'b0}}};
      next_base = ADDR_W'(page_base);
      final_pte = entry;
      final_pte[FLG_VALID] = ent_valid & ent_leaf;
   end

endmodule

// File: rtl/radix_pt_walker.sv
module radix_pt_walker
   import radix_pt_walker_pkg::*;
#(
   parameter int unsigned ADDR_W    = 64,
   parameter int unsigned PG_SHIFT  = 12,
   parameter int unsigned LEVELS    = 4,
   parameter int unsigned PTE_BYTES = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [ADDR_W-1:0] req_va,
   input  logic [ADDR_W-1:0] req_base,
   input  logic              xlate_en,
   input  logic [ADDR_W-1:0] mem_size,
   output logic              busy,
   output logic              mem_rd_valid,
   output logic [ADDR_W-1:0] mem_rd_addr,
   input  logic              mem_rsp_valid,
   input  logic [PTE_BYTES*8-1:0] mem_rsp_data,
   output logic              done,
   output logic [PTE_BYTES*8-1:0] result_pte
);

   localparam int unsigned PTE_W    = PTE_BYTES * 8;
   localparam int unsigned OFF_BITS = $clog2(PTE_BYTES);
   localparam int unsigned IDX_W    = PG_SHIFT - OFF_BITS;
   localparam int unsigned LVL_W    = (LEVELS > 1) ? $clog2(LEVELS) : 1;
   localparam logic [ADDR_W-1:0] PG_MASK = ADDR_W'((64'd1 << PG_SHIFT) - 64'd1);

   // elaboration-time parameter checks
   if (PTE_BYTES < 2 || (PTE_BYTES & (PTE_BYTES - 1)) != 0) begin : g_bad_pte
      $error("PTE_BYTES must be a power of two of at least 2");
   end
   if (PG_SHIFT < FLG_BITS || PG_SHIFT >= PTE_W) begin : g_bad_page
      $error("PG_SHIFT must hold the entry flags and leave a page number");
   end
   if (LEVELS < 1 || PG_SHIFT + LEVELS * IDX_W > ADDR_W) begin : g_bad_levels
      $error("LEVELS index fields do not fit in the virtual address");
   end

   walk_state_e       state_q;
   logic [ADDR_W-1:0] va_q;
   logic [ADDR_W-1:0] base_q;
   logic [LVL_W-1:0]  level_q;
   logic              done_q;
   logic [PTE_W-1:0]  result_q;

   logic [ADDR_W-1:0] entry_addr;
   logic              entry_oob;
   logic [PTE_W-1:0]  ident_pte;
   logic              step_stop;
   logic [ADDR_W-1:0] step_next_base;
   logic [PTE_W-1:0]  step_pte;

   radix_pt_walker_index_sel #(
      .ADDR_W   (ADDR_W),
      .PG_SHIFT (PG_SHIFT),
      .LEVELS   (LEVELS),
      .IDX_W    (IDX_W),
      .OFF_BITS (OFF_BITS),
      .LVL_W    (LVL_W)
   ) u_index (
      .va           (va_q),
      .base         (base_q),
      .level        (level_q),
      .mem_size     (mem_size),
      .entry_addr   (entry_addr),
      .out_of_range (entry_oob)
   );

   radix_pt_walker_identity #(
      .ADDR_W   (ADDR_W),
      .PTE_W    (PTE_W),
      .PG_SHIFT (PG_SHIFT)
   ) u_ident (
      .va       (req_va),
      .mem_size (mem_size),
      .pte      (ident_pte)
   );

   radix_pt_walker_step #(
      .ADDR_W   (ADDR_W),
      .PTE_W    (PTE_W),
      .PG_SHIFT (PG_SHIFT),
      .LVL_W    (LVL_W)
   ) u_step (
      .entry     (mem_rsp_data),
      .level     (level_q),
      .stop      (step_stop),
      .next_base (step_next_base),
      .final_pte (step_pte)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= WS_IDLE;
         va_q     <= '0;
         base_q   <= '0;
         level_q  <= '0;
         done_q   <= 1'b0;
         result_q <= '0;
      end else begin
         done_q <= 1'b0;
         unique case (state_q)
            WS_IDLE: begin
               if (req_valid) begin
                  if (!xlate_en) begin
                     result_q <= ident_pte;
                     done_q   <= 1'b1;
                  end else begin
                     va_q    <= req_va;
                     base_q  <= req_base & ~PG_MASK;
                     level_q <= LVL_W'(LEVELS - 1);
                     state_q <= WS_ISSUE;
                  end
               end
            end
            WS_ISSUE: begin
               if (entry_oob) begin
                  result_q <= '0;
                  done_q   <= 1'b1;
                  state_q  <= WS_IDLE;
               end else begin
                  state_q <= WS_WAIT;
               end
            end
            WS_WAIT: begin
               if (mem_rsp_valid) begin
                  if (step_stop) begin
                     result_q <= step_pte;
                     done_q   <= 1'b1;
                     state_q  <= WS_IDLE;
                  end else begin
                     base_q  <= step_next_base;
                     level_q <= level_q - LVL_W'(1);
                     state_q <= WS_ISSUE;
                  end
               end
            end
            default: state_q <= WS_IDLE;
         endcase
      end
   end

   assign busy         = (state_q != WS_IDLE);
   assign mem_rd_valid = (state_q == WS_ISSUE) && !entry_oob;
   assign mem_rd_addr  = entry_addr;
   assign done         = done_q;
   assign result_pte   = result_q;

endmodule

// File: rtl/radix_pt_walker_chk.sv
module radix_pt_walker_chk #(
   parameter int unsigned ADDR_W   = 64,
   parameter int unsigned PTE_W    = 64,
   parameter int unsigned OFF_BITS = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic              xlate_en,
   input logic [ADDR_W-1:0] mem_size,
   input logic              busy,
   input logic              mem_rd_valid,
   input logic [ADDR_W-1:0] mem_rd_addr,
   input logic              done,
   input logic [PTE_W-1:0]  result_pte
);

   AST_OFF_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !busy && !xlate_en) |=> (done && !busy)); // R2

   AST_RD_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd_valid |=> !mem_rd_valid); // R10

   AST_RD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd_valid |-> busy); // R10

   AST_RD_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd_valid |-> (mem_rd_addr < mem_size)); // R9

   AST_RD_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd_valid |-> (mem_rd_addr[OFF_BITS-1:0] == '0)); // R4

   AST_LEAF_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      (done && result_pte[0]) |-> result_pte[1]); // R3

   AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy); // R12

   AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !done |-> $stable(result_pte)); // R12

endmodule

bind radix_pt_walker radix_pt_walker_chk #(
   .ADDR_W   (ADDR_W),
   .PTE_W    (PTE_W),
   .OFF_BITS (OFF_BITS)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .req_valid    (req_valid),
   .xlate_en     (xlate_en),
   .mem_size     (mem_size),
   .busy         (busy),
   .mem_rd_valid (mem_rd_valid),
   .mem_rd_addr  (mem_rd_addr),
   .done         (done),
   .result_pte   (result_pte)
);

// File: tb/radix_pt_walker_tb_top.sv
`timescale 1ns/1ps
module radix_pt_walker_tb_top;

   typedef struct packed {
      logic [63:0] va;
      logic [63:0] base;
      logic [63:0] msz;
      logic [63:0] exp_pte;
      logic [63:0] exp_first;
      logic        en;
      logic [3:0]  lat;
      logic [3:0]  exp_reads;
   } vec_t;

   localparam int NVEC = 12;
   localparam vec_t VECS [NVEC] = '{
      // four-level walk ending on a leaf (R4 R5 R7)
      '{64'h0000_0080_8060_4123, 64'h1ABC, 64'h10_0000, 64'h552AB,  64'h1008, 1'b1, 4'd1, 4'd4},
      // leaf at level 2 (R7)
      '{64'h0000_0081_4000_0000, 64'h1ABC, 64'h10_0000, 64'h7773F3, 64'h1008, 1'b1, 4'd2, 4'd2},
      // invalid entry at level 1 (R6)
      '{64'h0000_0080_80E0_0000, 64'h1000, 64'h10_0000, 64'h9000,   64'h1008, 1'b1, 4'd3, 4'd3},
      // non-leaf at level 0 (R8)
      '{64'h0000_0080_8060_6000, 64'h1000, 64'h10_0000, 64'h8000,   64'h1008, 1'b1, 4'd1, 4'd4},
      // invalid root entry (R6)
      '{64'h0000_0480_0000_0000, 64'h1FFF, 64'h10_0000, 64'h0,      64'h1048, 1'b1, 4'd2, 4'd1},
      // level-0 entry exactly at memory end (R9)
      '{64'h0000_0080_8060_4123, 64'h1000, 64'h4020,    64'h0,      64'h1008, 1'b1, 4'd1, 4'd3},
      // one byte more memory: full walk (R9)
      '{64'h0000_0080_8060_4123, 64'h1000, 64'h4021,    64'h552AB,  64'h1008, 1'b1, 4'd2, 4'd4},
      // root entry out of range: no read (R9)
      '{64'h0000_0080_8060_4123, 64'h1000, 64'h1008,    64'h0,      64'h0,    1'b1, 4'd1, 4'd0},
      // translation off (R2)
      '{64'h0000_0000_0003_4567, 64'h1000, 64'h10_0000, 64'h343F3,  64'h0,    1'b0, 4'd1, 4'd0},
      '{64'h0000_0000_0010_0000, 64'h0,    64'h10_0000, 64'h1003F2, 64'h0,    1'b0, 4'd1, 4'd0},
      '{64'hFFFF_FFFF_FFFF_F000, 64'h0,    64'h10_0000, 64'hFFFF_FFFF_FFFF_F3F2, 64'h0, 1'b0, 4'd1, 4'd0},
      '{64'h0000_0000_000F_FFFF, 64'h0,    64'h10_0000, 64'hFF3F3,    64'h0,    1'b0, 4'd1, 4'd0}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [63:0] req_va = '0;
   logic [63:0] req_base = '0;
   logic        xlate_en = 1'b0;
   logic [63:0] mem_size = '0;
   logic        busy;
   logic        mem_rd_valid;
   logic [63:0] mem_rd_addr;
   logic        mem_rsp_valid = 1'b0;
   logic [63:0] mem_rsp_data = '0;
   logic        done;
   logic [63:0] result_pte;

   always #4 clk = ~clk;

   radix_pt_walker dut_i (
      .clk           (clk),
      .rst_n         (rst_n),
      .req_valid     (req_valid),
      .req_va        (req_va),
      .req_base      (req_base),
      .xlate_en      (xlate_en),
      .mem_size      (mem_size),
      .busy          (busy),
      .mem_rd_valid  (mem_rd_valid),
      .mem_rd_addr   (mem_rd_addr),
      .mem_rsp_valid (mem_rsp_valid),
      .mem_rsp_data  (mem_rsp_data),
      .done          (done),
      .result_pte    (result_pte)
   );

   int n_checks = 0;
   int n_err = 0;

   task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      n_checks++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // memory model
   logic [63:0] pmem [logic [63:0]];
   int          lat = 1;
   int          rd_count = 0;
   logic [63:0] rd_log [8];
   int          overlap_err = 0;
   bit          pend = 1'b0;
   int          pend_cnt = 0;
   logic [63:0] pend_addr = '0;

   function automatic logic [63:0] mem_rd(input logic [63:0] a);
      return pmem.exists(a) ? pmem[a] : 64'h0;
   endfunction

   initial begin
      forever begin
         @(negedge clk);
         mem_rsp_valid = 1'b0;
         if (!rst_n) begin
            pend = 1'b0;
         end else begin
            if (pend) begin
               if (pend_cnt <= 1) begin
                  mem_rsp_valid = 1'b1;
                  mem_rsp_data  = mem_rd(pend_addr);
                  pend = 1'b0;
               end else begin
                  pend_cnt--;
               end
            end
            if (mem_rd_valid) begin
               if (pend) overlap_err++;
               pend      = 1'b1;
               pend_cnt  = lat;
               pend_addr = mem_rd_addr;
               if (rd_count < 8) rd_log[rd_count] = mem_rd_addr;
               rd_count++;
            end
         end
      end
   end

   task automatic finish_run();
      $display("  Simulation finished: %0d checks, %0d errors", n_checks, n_err);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_checks++;
      n_err++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      finish_run();
   end

   task automatic run_vec(input vec_t v, input int id);
      int          cyc;
      int          busy_gap;
      logic [63:0] held;
      @(negedge clk);
      lat = int'(v.lat);
      rd_count = 0;
      req_va = v.va;
      req_base = v.base;
      mem_size = v.msz;
      xlate_en = v.en;
      req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      busy_gap = 0;
      if (!v.en) begin
         chk(done === 1'b1 && busy === 1'b0, $sformatf("R2 one-cycle completion vec %0d", id), 64'(done), 64'd1);
      end else begin
         chk(busy === 1'b1, $sformatf("R10 busy after accept vec %0d", id), 64'(busy), 64'd1);
         cyc = 0;
         while (done !== 1'b1 && cyc < 100) begin
            @(negedge clk);
            cyc++;
            if (done !== 1'b1 && busy !== 1'b1) busy_gap++;
         end
         chk(busy_gap == 0, $sformatf("R10 busy held vec %0d", id), 64'(busy_gap), 64'd0);
      end
      chk(done === 1'b1, $sformatf("R12 done seen vec %0d", id), 64'(done), 64'd1);
      chk(result_pte === v.exp_pte, $sformatf("R3/R6/R7/R8 result vec %0d", id), result_pte, v.exp_pte);
      chk(rd_count == int'(v.exp_reads), $sformatf("R9/R10 read count vec %0d", id), 64'(rd_count), 64'(v.exp_reads));
      if (v.exp_reads != 0)
         chk(rd_log[0] === v.exp_first, $sformatf("R4 first read vec %0d", id), rd_log[0], v.exp_first);
      held = result_pte;
      @(negedge clk);
      chk(done === 1'b0 && result_pte === held, $sformatf("R12 pulse and hold vec %0d", id), result_pte, held);
   endtask

   initial begin
      pmem[64'h1008] = 64'h2001;
      pmem[64'h2010] = 64'h3001;
      pmem[64'h3018] = 64'h4001;
      pmem[64'h4020] = 64'h552AB;
      pmem[64'h2028] = 64'h7773F3;
      pmem[64'h3038] = 64'h9000;
      pmem[64'h4030] = 64'h8001;

      // R1: reset state
      repeat (3) @(negedge clk);
      chk(busy === 1'b0 && done === 1'b0 && mem_rd_valid === 1'b0, "R1 outputs in reset", {61'd0, busy, done, mem_rd_valid}, 64'd0);
      chk(result_pte === 64'd0, "R1 result in reset", result_pte, 64'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(busy === 1'b0 && done === 1'b0 && result_pte === 64'd0, "R1 after release", result_pte, 64'd0);

      for (int i = 0; i < NVEC; i++) run_vec(VECS[i], i);

      // R5: full address sequence of the four-level walk
      run_vec(VECS[0], 100);
      chk(rd_log[1] === 64'h2010, "R5 level 2 read", rd_log[1], 64'h2010);
      chk(rd_log[2] === 64'h3018, "R5 level 1 read", rd_log[2], 64'h3018);
      chk(rd_log[3] === 64'h4020, "R5 level 0 read", rd_log[3], 64'h4020);

      // R11: request held during a whole walk, including the final response edge
      @(negedge clk);
      lat = 3;
      rd_count = 0;
      req_va = VECS[0].va;
      req_base = 64'h1000;
      mem_size = 64'h10_0000;
      xlate_en = 1'b1;
      req_valid = 1'b1;
      @(negedge clk);
      req_va = VECS[1].va;
      begin
         int cyc = 0;
         while (done !== 1'b1 && cyc < 100) begin
            @(negedge clk);
            cyc++;
         end
      end
      req_valid = 1'b0;
      chk(result_pte === 64'h552AB, "R11 result of first request", result_pte, 64'h552AB);
      chk(rd_log[1] === 64'h2010, "R11 path of first request", rd_log[1], 64'h2010);
      repeat (3) @(negedge clk);
      chk(rd_count == 4 && busy === 1'b0 && done === 1'b0, "R11 stray request dropped", 64'(rd_count), 64'd4);

      // R1: reset during a walk
      @(negedge clk);
      lat = 3;
      req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b0;
      #1;
      chk(busy === 1'b0 && mem_rd_valid === 1'b0 && done === 1'b0, "R1 reset aborts walk", 64'(busy), 64'd0);
      chk(result_pte === 64'd0, "R1 result cleared", result_pte, 64'd0);
      @(negedge clk);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      chk(overlap_err == 0, "R10 single outstanding read", 64'(overlap_err), 64'd0);
      finish_run();
   end

endmodule